// File: doc/BRIEF.md
# I2C Register-Access Bridge Controller

This block is the control state machine placed behind a byte-level I2C slave engine. The engine handles bit timing, START/STOP detection and slave-address matching. Each time it completes a byte it gives one `done_p` pulse together with a status code, the current read/write operation bit and the received byte. The controller turns the byte stream into single Wishbone master cycles on a 12-bit register address with 32-bit data.

A host starts an access with the control byte. Two address bytes follow. The controller first tests the assembled address with a probe read cycle, and it continues only if the slave acknowledges. If the host then keeps writing, four data bytes are gathered, least significant first, and one Wishbone write is issued. If the host instead issues a repeated start with the operation bit flipped, the controller performs a real Wishbone read and hands the four result bytes back to the engine in the same byte order. Any status the current step does not expect returns the controller to idle, and so does a STOP or a Wishbone cycle that gets no acknowledge.

Status codes on `eng_stat`: 0 = control byte matched, 1 = byte received from the host, 2 = byte sent to the host, 3 = STOP seen.

Top module: `i2c_wb_regbridge`

## Requirements
- R1: Under synchronous reset the controller is idle: `wb_cyc`, `wb_stb`, `wb_we` are low, `wb_sel` is 0 and `rsp_ack` is 1.
- R2: The controller changes state only on a `done_p` pulse or on the end of its own Wishbone cycle. In idle, only status 0 (control byte matched) starts a transaction; bytes reported with status 1 or 2 in idle start no Wishbone cycle.
- R3: The two bytes received after the control byte form the register address, first byte most significant: `wb_adr` = {first[3:0], second}, and the upper four bits of the first byte are dropped.
- R4: One clock after the second address byte's `done_p`, a probe cycle starts: `wb_cyc`/`wb_stb` high with `wb_we` low on the new address. The controller waits for a data byte or a repeated start only after the probe is acknowledged.
- R5: If the probe gets no acknowledge within 16 clocks, `wb_cyc` drops and the controller returns to idle with `rsp_ack` low, so the host's next byte is NACKed. `rsp_ack` returns high on the next control-byte match.
- R6: When the operation bit is unchanged after the probe, four received bytes are assembled least significant byte first, and one clock after the fourth byte's `done_p` a Wishbone write (`wb_we` high) of that word to the stored address starts.
- R7: When a control-byte match arrives after the probe with the operation bit different from the one recorded at the start of the transaction, a Wishbone read of the stored address is performed. `tx_byte` then presents the result's bits [7:0], and advances to [15:8], [23:16] and [31:24] on successive status-2 `done_p` pulses. After the fourth, the controller is idle.
- R8: A STOP (status 3), or any status other than the one the current step expects, returns the controller to idle without any Wishbone write.
- R9: `wb_cyc` and `wb_stb` stay high from the start of a cycle until the clock edge where `wb_ack` is seen. `wb_sel` is all ones during every cycle, and `wb_we` is high only during the write cycle.
- R10: A write or read cycle that gets no acknowledge is dropped after 16 clocks of `wb_cyc`, and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_p | input | 1 | One-cycle pulse: engine finished a byte |
| eng_stat | input | 2 | Engine status for that byte (0 match, 1 rx, 2 tx, 3 STOP) |
| eng_op | input | 1 | Current operation bit from the engine (1 = host reads) |
| rx_byte | input | 8 | Byte received from the host |
| tx_byte | output | 8 | Byte for the engine to send to the host |
| rsp_ack | output | 1 | 1 = ACK the next host byte, 0 = NACK |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_sel | output | 4 | Wishbone byte selects |
| wb_adr | output | 12 | Wishbone register address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_ack | input | 1 | Wishbone acknowledge |
| wb_dat_i | input | 32 | Wishbone read data |

## Verification
Every result of this block is due a fixed number of edges after its cause. Address and write-data registers change on the edge that samples `done_p`. A Wishbone cycle opens on that same edge, so it is visible one clock after the pulse. The cycle closes on the edge that sees `wb_ack`, or after 16 clocks of `wb_cyc`. `tx_byte` takes the read data on the acknowledging edge and moves on at each status-2 pulse. `rsp_ack` falls on the edge where the probe times out. The bench keeps a behavioural model that advances on each rising edge from the same inputs. It compares every output with that model on each falling edge, away from the edge where the design updates. Directed checks on memory contents, cycle lengths and `rsp_ack` are sampled only after the 20-clock settling waits that follow each stimulus.

// File: rtl/i2cwb_pkg.sv
package i2cwb_pkg;

  typedef enum logic [1:0] {
    ES_MATCH = 2'd0,
    ES_RX    = 2'd1,
    ES_TX    = 2'd2,
    ES_STOP  = 2'd3
  } eng_stat_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_ADR,
    F_PROBE,
    F_OPCHK,
    F_WRBYTE,
    F_WBWR,
    F_WBRD,
    F_RDBYTE
  } fsm_e;

endpackage

// File: rtl/i2cwb_cycle.sv
module i2cwb_cycle #(
  parameter int SEL_W   = 4,
  parameter int TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             go_we,
  input  logic             wb_ack,
  output logic             cyc,
  output logic             stb,
  output logic             we,
  output logic [SEL_W-1:0] sel,
  output logic             fin_ok,
  output logic             fin_err
);
  localparam int TW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);

  logic [TW-1:0] tmo;

  assign fin_ok  = cyc & wb_ack;
  assign fin_err = cyc & ~wb_ack & (tmo == TLAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc <= 1'b0;
      stb <= 1'b0;
      we  <= 1'b0;
      sel <= '0;
      tmo <= '0;
    end else if (go) begin
      cyc <= 1'b1;
      stb <= 1'b1;
      we  <= go_we;
      sel <= '1;
      tmo <= '0;
    end else if (fin_ok || fin_err) begin
      cyc <= 1'b0;
      stb <= 1'b0;
      we  <= 1'b0;
      sel <= '0;
    end else if (cyc) begin
      tmo <= tmo + 1'b1;
    end
  end

  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (rst)
    (cyc && !wb_ack && tmo != TLAST) |=> (cyc && stb)); // R9
  AST_SEL_FULL: assert property (@(posedge clk) disable iff (rst)
    cyc |-> (sel == {SEL_W{1'b1}})); // R9
  AST_DROP_ON_TMO: assert property (@(posedge clk) disable iff (rst)
    fin_err |=> !cyc); // R10

endmodule

// File: rtl/i2cwb_rx_pack.sv
module i2cwb_rx_pack #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adr_shift,
  input  logic          dat_shift,
  input  logic [BW-1:0] in_byte,
  output logic [AW-1:0] adr,
  output logic [DW-1:0] dat
);

  generate
    if (AW > BW) begin : g_wide_adr
      always_ff @(posedge clk) begin
        if (rst)            adr <= '0;
        else if (adr_shift) adr <= {adr[AW-BW-1:0], in_byte};
      end
    end else begin : g_narrow_adr
      always_ff @(posedge clk) begin
        if (rst)            adr <= '0;
        else if (adr_shift) adr <= in_byte[AW-1:0];
      end
    end
  endgenerate

  // Least significant byte arrives first: shift in from the top.
  always_ff @(posedge clk) begin
    if (rst)            dat <= '0;
    else if (dat_shift) dat <= {in_byte, dat[DW-1:BW]};
  end

endmodule

// File: rtl/i2cwb_tx_unpack.sv
module i2cwb_tx_unpack #(
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          shift,
  input  logic [DW-1:0] word,
  output logic [BW-1:0] out_byte
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= word;
    else if (shift) sh <= sh >> BW;
  end

  assign out_byte = sh[BW-1:0];

endmodule

// File: rtl/i2c_wb_regbridge.sv
module i2c_wb_regbridge
  import i2cwb_pkg::*;
#(
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_p,
  input  logic [1:0]        eng_stat,
  input  logic              eng_op,
  input  logic [7:0]        rx_byte,
  output logic [7:0]        tx_byte,
  output logic              rsp_ack,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [DW/8-1:0]   wb_sel,
  output logic [AW-1:0]     wb_adr,
  output logic [DW-1:0]     wb_dat_o,
  input  logic              wb_ack,
  input  logic [DW-1:0]     wb_dat_i
);
  localparam int BW   = 8;
  localparam int NB   = DW / BW;
  localparam int AB   = (AW + BW - 1) / BW;
  localparam int SELW = DW / 8;
  localparam int CW   = (NB > 2) ? $clog2(NB) : 1;
  localparam logic [CW-1:0] LAST_DAT = CW'(NB - 1);
  localparam logic [CW-1:0] LAST_ADR = CW'(AB - 1);

  fsm_e      st, st_n;
  eng_stat_e sts;
  logic [CW-1:0] cnt;
  logic op0, nack;
  logic go, go_we, adr_sh, dat_sh, tx_ld, tx_sh;
  logic cnt_clr, cnt_inc, nack_set, nack_clr, op0_ld;
  logic cyc_ok, cyc_err;

  assign sts = eng_stat_e'(eng_stat);

  always_comb begin
    st_n     = st;
    go       = 1'b0;
    go_we    = 1'b0;
    adr_sh   = 1'b0;
    dat_sh   = 1'b0;
    tx_ld    = 1'b0;
    tx_sh    = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    nack_set = 1'b0;
    nack_clr = 1'b0;
    op0_ld   = 1'b0;
    unique case (st)
      F_IDLE: begin
        if (done_p && sts == ES_MATCH) begin
          st_n     = F_ADR;
          cnt_clr  = 1'b1;
          nack_clr = 1'b1;
          op0_ld   = 1'b1;
        end
      end
      F_ADR: begin
        if (done_p) begin
          if (sts == ES_RX) begin
            adr_sh = 1'b1;
            if (cnt == LAST_ADR) begin
              st_n    = F_PROBE;
              go      = 1'b1;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end else begin
            st_n = F_IDLE;
          end
        end
      end
      F_PROBE: begin
        if (cyc_ok) begin
          st_n = F_OPCHK;
        end else if (cyc_err) begin
          st_n     = F_IDLE;
          nack_set = 1'b1;
        end
      end
      F_OPCHK: begin
        if (done_p) begin
          if (sts == ES_MATCH && eng_op != op0) begin
            st_n = F_WBRD;
            go   = 1'b1;
          end else if (sts == ES_RX && eng_op == op0) begin
            dat_sh  = 1'b1;
            cnt_inc = 1'b1;
            st_n    = F_WRBYTE;
          end else begin
            st_n = F_IDLE;
          end
        end
      end
      F_WRBYTE: begin
        if (done_p) begin
          if (sts == ES_RX) begin
            dat_sh = 1'b1;
            if (cnt == LAST_DAT) begin
              st_n    = F_WBWR;
              go      = 1'b1;
              go_we   = 1'b1;
              cnt_clr = 1'b1;
            end else begin
              cnt_inc = 1'b1;
            end
          end else begin
            st_n = F_IDLE;
          end
        end
      end
      F_WBWR: begin
        if (cyc_ok || cyc_err) st_n = F_IDLE;
      end
      F_WBRD: begin
        if (cyc_ok) begin
          tx_ld   = 1'b1;
          cnt_clr = 1'b1;
          st_n    = F_RDBYTE;
        end else if (cyc_err) begin
          st_n = F_IDLE;
        end
      end
      F_RDBYTE: begin
        if (done_p) begin
          if (sts == ES_TX) begin
            tx_sh = 1'b1;
            if (cnt == LAST_DAT) st_n = F_IDLE;
            else                 cnt_inc = 1'b1;
          end else begin
            st_n = F_IDLE;
          end
        end
      end
      default: st_n = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= F_IDLE;
      cnt  <= '0;
      op0  <= 1'b0;
      nack <= 1'b0;
    end else begin
      st <= st_n;
      if (cnt_clr)      cnt <= '0;
      else if (cnt_inc) cnt <= cnt + 1'b1;
      if (op0_ld)       op0 <= eng_op;
      if (nack_set)      nack <= 1'b1;
      else if (nack_clr) nack <= 1'b0;
    end
  end

  assign rsp_ack = ~nack;

  i2cwb_cycle #(
    .SEL_W   (SELW),
    .TIMEOUT (TIMEOUT)
  ) u_cycle (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .go_we   (go_we),
    .wb_ack  (wb_ack),
    .cyc     (wb_cyc),
    .stb     (wb_stb),
    .we      (wb_we),
    .sel     (wb_sel),
    .fin_ok  (cyc_ok),
    .fin_err (cyc_err)
  );

  i2cwb_rx_pack #(
    .AW (AW),
    .DW (DW),
    .BW (BW)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .adr_shift (adr_sh),
    .dat_shift (dat_sh),
    .in_byte   (rx_byte),
    .adr       (wb_adr),
    .dat       (wb_dat_o)
  );

  i2cwb_tx_unpack #(
    .DW (DW),
    .BW (BW)
  ) u_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (tx_ld),
    .shift    (tx_sh),
    .word     (wb_dat_i),
    .out_byte (tx_byte)
  );

  AST_HOLD_WITHOUT_DONE: assert property (@(posedge clk) disable iff (rst)
    (!done_p && (st == F_IDLE || st == F_ADR || st == F_OPCHK || st == F_WRBYTE || st == F_RDBYTE))
      |=> $stable(st)); // R2
  AST_PROBE_IS_READ: assert property (@(posedge clk) disable iff (rst)
    (st == F_PROBE && wb_cyc) |-> !wb_we); // R4
  AST_NACK_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    (st == F_PROBE && cyc_err) |=> !rsp_ack); // R5
  AST_WRITE_AFTER_BYTES: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_we) |-> ($past(st) == F_WRBYTE)); // R6
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (done_p && sts == ES_STOP &&
     (st == F_ADR || st == F_OPCHK || st == F_WRBYTE || st == F_RDBYTE))
      |=> (st == F_IDLE && !wb_cyc)); // R8
  AST_WE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> (st == F_WBWR && wb_cyc)); // R9

endmodule

// File: tb/test_i2c_wb_regbridge.sv
module test_i2c_wb_regbridge;
  localparam int TMO = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        done_p = 1'b0;
  logic [1:0]  stat = 2'd0;
  logic        op = 1'b0;
  logic [7:0]  rxb = 8'h00;
  logic        ack_r = 1'b0;
  logic [31:0] dat_r = 32'h0;
  logic [7:0]  txb;
  logic        rsp_ack, cyc, stb, we;
  logic [3:0]  sel;
  logic [11:0] adr;
  logic [31:0] dat_o;

  int tests = 0;
  int fails = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  i2c_wb_regbridge i_i2c_wb_regbridge (
    .clk(clk), .rst(rst), .done_p(done_p), .eng_stat(stat), .eng_op(op),
    .rx_byte(rxb), .tx_byte(txb), .rsp_ack(rsp_ack), .wb_cyc(cyc),
    .wb_stb(stb), .wb_we(we), .wb_sel(sel), .wb_adr(adr), .wb_dat_o(dat_o),
    .wb_ack(ack_r), .wb_dat_i(dat_r)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Wishbone slave with a small register space
  logic [31:0] mem [int];
  int  ack_dly = 0;
  bit  stall = 1'b0;
  int  wcnt = 0;
  int  run = 0;
  int  last_len = 0;
  int  n_cyc = 0;

  always @(negedge clk) begin
    if (cyc) begin
      if (run == 0) n_cyc++;
      run++;
    end else begin
      if (run != 0) last_len = run;
      run = 0;
    end
    if (ack_r) begin
      ack_r = 1'b0;
      wcnt  = 0;
    end else if (cyc && stb && !stall && mem.exists(int'(adr))) begin
      if (wcnt == ack_dly) begin
        ack_r = 1'b1;
        dat_r = mem[int'(adr)];
        wcnt  = 0;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  always @(posedge clk) begin
    if (ack_r && cyc && we) mem[int'(adr)] = dat_o;
  end

  // Behavioural reference model, advanced at each rising edge
  int m_ph, m_n, m_t;
  bit m_op0, m_nack, m_cyc, m_we, m_ok, m_err, m_go, m_gowe;
  logic [11:0] m_adr;
  logic [31:0] m_dat, m_sh;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_n = 0; m_t = 0; m_op0 = 0; m_nack = 0; m_cyc = 0; m_we = 0;
      m_adr = 0; m_dat = 0; m_sh = 0;
    end else begin
      m_ok  = m_cyc && ack_r;
      m_err = m_cyc && !ack_r && (m_t == TMO - 1);
      m_go = 0; m_gowe = 0;
      case (m_ph)
        0: if (done_p && stat == 2'd0) begin m_op0 = op; m_nack = 0; m_n = 0; m_ph = 1; end
        1: if (done_p) begin
             if (stat == 2'd1) begin
               m_adr = {m_adr[3:0], rxb};
               if (m_n == 1) begin m_ph = 2; m_go = 1; m_n = 0; end else m_n++;
             end else m_ph = 0;
           end
        2: if (m_ok) m_ph = 3; else if (m_err) begin m_ph = 0; m_nack = 1; end
        3: if (done_p) begin
             if (stat == 2'd0 && op != m_op0) begin m_ph = 6; m_go = 1; end
             else if (stat == 2'd1 && op == m_op0) begin
               m_dat = {rxb, m_dat[31:8]}; m_n = 1; m_ph = 4;
             end else m_ph = 0;
           end
        4: if (done_p) begin
             if (stat == 2'd1) begin
               m_dat = {rxb, m_dat[31:8]};
               if (m_n == 3) begin m_ph = 5; m_go = 1; m_gowe = 1; m_n = 0; end else m_n++;
             end else m_ph = 0;
           end
        5: if (m_ok || m_err) m_ph = 0;
        6: if (m_ok) begin m_sh = dat_r; m_n = 0; m_ph = 7; end else if (m_err) m_ph = 0;
        7: if (done_p) begin
             if (stat == 2'd2) begin
               m_sh = m_sh >> 8;
               if (m_n == 3) m_ph = 0; else m_n++;
             end else m_ph = 0;
           end
        default: m_ph = 0;
      endcase
      if (m_go) begin m_cyc = 1; m_we = m_gowe; m_t = 0; end
      else if (m_ok || m_err) begin m_cyc = 0; m_we = 0; end
      else if (m_cyc) m_t++;
    end
  end

  // Compare every output with the model on each falling edge
  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk("R9", "wb_cyc", {31'b0, cyc}, {31'b0, m_cyc});
      chk("R9", "wb_stb", {31'b0, stb}, {31'b0, m_cyc});
      chk("R9", "wb_we",  {31'b0, we},  {31'b0, m_we});
      chk("R9", "wb_sel", {28'b0, sel}, m_cyc ? 32'hF : 32'h0);
      chk("R3", "wb_adr", {20'b0, adr}, {20'b0, m_adr});
      chk("R6", "wb_dat_o", dat_o, m_dat);
      chk("R7", "tx_byte", {24'b0, txb}, {24'b0, m_sh[7:0]});
      chk("R5", "rsp_ack", {31'b0, rsp_ack}, {31'b0, !m_nack});
    end
  end

  task automatic ev(input logic [1:0] s, input logic o, input logic [7:0] b);
    @(negedge clk);
    done_p = 1'b1; stat = s; op = o; rxb = b;
    @(negedge clk);
    done_p = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic addr_phase(input logic [11:0] a);
    ev(2'd0, 1'b0, 8'h00);
    ev(2'd1, 1'b0, {4'hA, a[11:8]});
    ev(2'd1, 1'b0, a[7:0]);
    settle();
  endtask

  task automatic wr_txn(input logic [11:0] a, input logic [31:0] d,
                        input int dly, input bit stall_data);
    ack_dly = dly; stall = 1'b0;
    addr_phase(a);
    stall = stall_data;
    for (int i = 0; i < 4; i++) ev(2'd1, 1'b0, d[8*i +: 8]);
    settle();
    ev(2'd3, 1'b0, 8'h00);
    stall = 1'b0;
  endtask

  initial begin
    int nc;
    mem[12'h123] = 32'h0;
    mem[12'hABC] = 32'h0;
    mem[12'h040] = 32'h0102_0304;
    repeat (3) @(negedge clk);
    chk("R1", "reset wb_cyc", {31'b0, cyc}, 32'h0);
    chk("R1", "reset wb_we",  {31'b0, we},  32'h0);
    chk("R1", "reset wb_sel", {28'b0, sel}, 32'h0);
    chk("R1", "reset rsp_ack", {31'b0, rsp_ack}, 32'h1);
    rst = 1'b0;
    cmp_en = 1'b1;

    // R2: received / sent bytes while idle start nothing
    nc = n_cyc;
    ev(2'd1, 1'b0, 8'h12);
    ev(2'd1, 1'b0, 8'h34);
    ev(2'd2, 1'b0, 8'h00);
    settle();
    chk("R2", "cycles started from idle", n_cyc, nc);

    // R3/R6/R9: write with immediate ack
    wr_txn(12'h123, 32'hDEAD_BEEF, 0, 1'b0);
    chk("R6", "mem[123]", mem[12'h123], 32'hDEAD_BEEF);
    chk("R3", "address", {20'b0, adr}, 32'h123);
    chk("R9", "write cycle length", last_len, 1);

    // R4: probe seen as a read while the slave is slow
    ack_dly = 5;
    ev(2'd0, 1'b0, 8'h00);
    ev(2'd1, 1'b0, 8'h0A);
    ev(2'd1, 1'b0, 8'hBC);
    chk("R4", "probe cyc", {31'b0, cyc}, 32'h1);
    chk("R4", "probe we", {31'b0, we}, 32'h0);
    settle();
    chk("R4", "probe length", last_len, 6);
    for (int i = 0; i < 4; i++) ev(2'd1, 1'b0, 8'h10 + 8'(i));
    settle();
    chk("R6", "mem[ABC]", mem[12'hABC], 32'h1312_1110);
    chk("R9", "held until ack", last_len, 6);
    ev(2'd3, 1'b0, 8'h00);

    // R7: read back through a repeated start
    ack_dly = 2;
    addr_phase(12'h123);
    ev(2'd0, 1'b1, 8'h00);
    settle();
    for (int i = 0; i < 4; i++) begin
      chk("R7", "read byte", {24'b0, txb}, {24'b0, mem[12'h123][8*i +: 8]});
      ev(2'd2, 1'b1, 8'h00);
    end
    ev(2'd3, 1'b0, 8'h00);
    addr_phase(12'h040);
    ev(2'd0, 1'b1, 8'h00);
    settle();
    for (int i = 0; i < 4; i++) begin
      chk("R7", "read byte 040", {24'b0, txb}, {24'b0, 8'(4 - i)});
      ev(2'd2, 1'b1, 8'h00);
    end

    // R5: probe to a missing register
    ack_dly = 0;
    addr_phase(12'h7FF);
    chk("R5", "probe timeout length", last_len, TMO);
    chk("R5", "rsp_ack after miss", {31'b0, rsp_ack}, 32'h0);
    nc = n_cyc;
    ev(2'd1, 1'b0, 8'h55);
    settle();
    chk("R5", "still NACK", {31'b0, rsp_ack}, 32'h0);
    chk("R8", "no cycle after miss", n_cyc, nc);
    chk("R8", "no write to 7FF", {31'b0, mem.exists(12'h7FF)}, 32'h0);
    ev(2'd0, 1'b0, 8'h00);
    chk("R5", "rsp_ack restored", {31'b0, rsp_ack}, 32'h1);
    ev(2'd3, 1'b0, 8'h00);

    // R8: STOP in the middle of the data bytes
    addr_phase(12'hABC);
    ev(2'd1, 1'b0, 8'hAA);
    ev(2'd1, 1'b0, 8'hBB);
    ev(2'd3, 1'b0, 8'h00);
    ev(2'd1, 1'b0, 8'hCC);
    ev(2'd1, 1'b0, 8'hDD);
    settle();
    chk("R8", "mem[ABC] after STOP", mem[12'hABC], 32'h1312_1110);

    // R8: unexpected status during address bytes
    nc = n_cyc;
    ev(2'd0, 1'b0, 8'h00);
    ev(2'd2, 1'b0, 8'h00);
    ev(2'd1, 1'b0, 8'h01);
    ev(2'd1, 1'b0, 8'h23);
    settle();
    chk("R8", "no probe after bad status", n_cyc, nc);

    // R10: write and read cycles that never get an ack
    wr_txn(12'h123, 32'h5555_AAAA, 1, 1'b1);
    chk("R10", "write timeout length", last_len, TMO);
    chk("R10", "mem[123] kept", mem[12'h123], 32'hDEAD_BEEF);
    addr_phase(12'h040);
    stall = 1'b1;
    ev(2'd0, 1'b1, 8'h00);
    settle();
    stall = 1'b0;
    chk("R10", "read timeout length", last_len, TMO);
    chk("R10", "idle after read timeout", {31'b0, cyc}, 32'h0);
    ev(2'd3, 1'b0, 8'h00);

    cmp_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule